// File: doc/BRIEF.md
# Register-Pair Arithmetic Right Shift Unit

This execution unit carries out a double-width arithmetic right shift on a machine with sixteen 32-bit general registers. An instruction names the even register of an even/odd pair. The unit treats that pair as one signed 64-bit value, with the even register as the upper half. It forms an address from a base register plus a displacement, takes the low six bits of that address as the shift distance, and accesses no memory. The shifted value goes back into the pair through a single register-file write port. The unit then sets a 2-bit condition code that gives the sign of the result.

A sequencer starts the unit with a one-cycle `startValid` pulse while `ready` is high. The three register-file read ports are combinational and are sampled one cycle after the start. The upper half is written back on the next cycle and the lower half on the cycle after that. `done` follows one cycle later, together with the new condition code. If an instruction names an odd register as the pair, the unit reports a specification error and changes no state.

Top module: `pair_shift_unit`

## Requirements
- R1: The instruction word is opcode [31:24], pair register [23:20], unused [19:16], base register [15:12] and displacement [11:0]. The register `{pair[3:1],0}` supplies bits 63..32 of the operand and `{pair[3:1],1}` supplies bits 31..0. The upper result is written to the even address in the second cycle after the start, and the lower result to the odd address in the following cycle.
- R2: The shift distance is bits [5:0] of base contents plus zero-extended displacement, and carries above bit 5 are dropped. A base field of 0 contributes zero, whatever register 0 holds.
- R3: Bits shifted out on the right are lost. Vacated bits on the left take the value of bit 63, and bit 63 itself is unchanged.
- R4: The condition code is 0 for a zero result, 1 for a negative result and 2 for a positive result. The value 3 never appears.
- R5: The opcode byte and bits [19:16] have no effect on the result.
- R6: A distance of 32 moves the even register's value into the odd register and fills the even register with sign copies.
- R7: A distance of 63 gives all sign bits: zero for a non-negative operand and all ones for a negative one.
- R8: An odd pair field raises `specErr` for exactly one cycle, the cycle after the start. No write and no `done` follow, and the condition code keeps its value.
- R9: `done` is high for one cycle, directly after the lower-half write, and the condition code changes only at that moment. `ready` is low from the cycle after a start until `done` or `specErr` has been shown. A start pulse seen while `ready` is low is ignored.
- R10: After reset `ready` is high, `wrEn`, `done` and `specErr` are low, and the condition code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, accepted when `ready` is high |
| instrWord | input | 32 | Instruction word |
| ready | output | 1 | Unit idle and able to accept a start |
| rdAddrHi | output | 4 | Read address of the even register |
| rdDataHi | input | 32 | Even register contents |
| rdAddrLo | output | 4 | Read address of the odd register |
| rdDataLo | input | 32 | Odd register contents |
| rdAddrBase | output | 4 | Read address of the base register |
| rdDataBase | input | 32 | Base register contents |
| wrEn | output | 1 | Register write enable |
| wrAddr | output | 4 | Register write address |
| wrData | output | 32 | Register write data |
| done | output | 1 | Completion strobe |
| condCode | output | 2 | Condition code |
| specErr | output | 1 | Odd pair register specification error |

## Verification
The assertions assume that the register file answers reads combinationally and holds its contents steady during the cycle after a start, and that `startValid` is a single-cycle pulse. The bench drives the register file from its own array, updates that array only through the unit's write port, and raises start only when `ready` is high, except in the deliberate busy-time pulses that test whether a start is ignored. Under these assumptions the pair write order, the timing of `done` and the stability of the condition code can all be checked from the ports.

// File: rtl/pair_shift_pkg.sv
package pair_shift_pkg;

  typedef struct packed {
    logic latch;    // take instruction fields
    logic capture;  // take operands and form shifted result
    logic wrHi;     // present upper half on write port
    logic wrLo;     // present lower half on write port
    logic ccLoad;   // update condition code
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WHI,
    ST_WLO,
    ST_FIN,
    ST_ERR
  } state_t;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_POS  = 2'd2;

endpackage

// File: rtl/pair_shift_dp.sv
module pair_shift_dp
  import pair_shift_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DISP_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-2:0] pairSel,
  input  logic [ADDR_W-1:0] baseSel,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] rdAddrHi,
  output logic [ADDR_W-1:0] rdAddrLo,
  output logic [ADDR_W-1:0] rdAddrBase,
  input  logic [REG_W-1:0]  rdDataHi,
  input  logic [REG_W-1:0]  rdDataLo,
  input  logic [REG_W-1:0]  rdDataBase,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [REG_W-1:0]  wrData,
  output logic [1:0]        condCode
);

  localparam int PAIR_W = 2 * REG_W;

  logic [ADDR_W-2:0] pairQ;
  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  dispQ;
  logic [CNT_W-1:0]  baseLow;
  logic [CNT_W-1:0]  shiftCnt;
  logic signed [PAIR_W-1:0] operand;
  logic signed [PAIR_W-1:0] shifted;
  logic [PAIR_W-1:0] resQ;
  logic [1:0]        ccQ;
  logic [1:0]        ccNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairQ <= '0;
      baseQ <= '0;
      dispQ <= '0;
    end else if (ctrl.latch) begin
      pairQ <= pairSel;
      baseQ <= baseSel;
      dispQ <= disp[CNT_W-1:0];
    end
  end

  assign rdAddrHi   = {pairQ, 1'b0};
  assign rdAddrLo   = {pairQ, 1'b1};
  assign rdAddrBase = baseQ;

  // only the low count bits of the address matter, so the adder stops there
  assign baseLow  = (baseQ == '0) ? '0 : rdDataBase[CNT_W-1:0];
  assign shiftCnt = baseLow + dispQ;
  assign operand  = {rdDataHi, rdDataLo};
  assign shifted  = operand >>> shiftCnt;

  always_ff @(posedge clk) begin
    if (!rstN) resQ <= '0;
    else if (ctrl.capture) resQ <= shifted;
  end

  assign wrAddr = ctrl.wrLo ? {pairQ, 1'b1} : {pairQ, 1'b0};
  assign wrData = ctrl.wrLo ? resQ[REG_W-1:0] : resQ[PAIR_W-1:REG_W];

  always_comb begin
    if (resQ == '0)            ccNext = CC_ZERO;
    else if (resQ[PAIR_W-1])   ccNext = CC_NEG;
    else                       ccNext = CC_POS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ccQ <= CC_ZERO;
    else if (ctrl.ccLoad) ccQ <= ccNext;
  end

  assign condCode = ccQ;

endmodule

// File: rtl/pair_shift_ctrl.sv
module pair_shift_ctrl
  import pair_shift_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startValid,
  input  logic  pairOdd,
  output ctrl_t ctrl,
  output logic  ready,
  output logic  wrEn,
  output logic  done,
  output logic  specErr
);

  state_t state, stateNext;
  logic   accept;

  assign accept = (state == ST_IDLE) && startValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startValid) stateNext = pairOdd ? ST_ERR : ST_READ;
      ST_READ: stateNext = ST_WHI;
      ST_WHI:  stateNext = ST_WLO;
      ST_WLO:  stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      ST_ERR:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl         = '0;
    ctrl.latch   = accept && !pairOdd;
    ctrl.capture = (state == ST_READ);
    ctrl.wrHi    = (state == ST_WHI);
    ctrl.wrLo    = (state == ST_WLO);
    ctrl.ccLoad  = (state == ST_WLO);
  end

  assign ready   = (state == ST_IDLE);
  assign wrEn    = ctrl.wrHi || ctrl.wrLo;
  assign done    = (state == ST_FIN);
  assign specErr = (state == ST_ERR);

endmodule

// File: rtl/pair_shift_unit.sv
module pair_shift_unit
  import pair_shift_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DISP_W = 12,
  parameter int CNT_W  = 6,
  parameter int OP_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startValid,
  input  logic [OP_W+3*ADDR_W+DISP_W-1:0] instrWord,
  output logic                          ready,
  output logic [ADDR_W-1:0]             rdAddrHi,
  input  logic [REG_W-1:0]              rdDataHi,
  output logic [ADDR_W-1:0]             rdAddrLo,
  input  logic [REG_W-1:0]              rdDataLo,
  output logic [ADDR_W-1:0]             rdAddrBase,
  input  logic [REG_W-1:0]              rdDataBase,
  output logic                          wrEn,
  output logic [ADDR_W-1:0]             wrAddr,
  output logic [REG_W-1:0]              wrData,
  output logic                          done,
  output logic [1:0]                    condCode,
  output logic                          specErr
);

  localparam int BASE_LSB = DISP_W;
  localparam int PAIR_LSB = DISP_W + 2 * ADDR_W;

  ctrl_t ctrl;

  pair_shift_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .pairOdd    (instrWord[PAIR_LSB]),
    .ctrl       (ctrl),
    .ready      (ready),
    .wrEn       (wrEn),
    .done       (done),
    .specErr    (specErr)
  );

  pair_shift_dp #(
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .pairSel    (instrWord[PAIR_LSB+1 +: ADDR_W-1]),
    .baseSel    (instrWord[BASE_LSB +: ADDR_W]),
    .disp       (instrWord[DISP_W-1:0]),
    .rdAddrHi   (rdAddrHi),
    .rdAddrLo   (rdAddrLo),
    .rdAddrBase (rdAddrBase),
    .rdDataHi   (rdDataHi),
    .rdDataLo   (rdDataLo),
    .rdDataBase (rdDataBase),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .condCode   (condCode)
  );

endmodule

// File: rtl/pair_shift_checker.sv
module pair_shift_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done,
  input logic [1:0]        condCode,
  input logic              specErr
);

  assert_pair_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr[0]) |=> (wrEn && wrAddr == $past(wrAddr) + 1'b1));

  assert_odd_after_even_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[0]) |-> ($past(wrEn) && !$past(wrAddr[0])));

  assert_cc_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    condCode != 2'd3);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    specErr |=> (!wrEn && !done && !specErr));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, done, specErr}));

  assert_done_after_lo_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(wrEn) && $past(wrAddr[0])));

  assert_cc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(condCode));

  assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || done || specErr) |-> !ready);

endmodule

bind pair_shift_unit pair_shift_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .done     (done),
  .condCode (condCode),
  .specErr  (specErr)
);

// File: tb/pair_shift_unit_tb.sv
module pair_shift_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        ready, wrEn, done, specErr;
  logic [3:0]  rdAddrHi, rdAddrLo, rdAddrBase, wrAddr;
  logic [31:0] wrData;
  logic [1:0]  condCode;

  logic [31:0] regs [16];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0] expCc = 2'd0;

  always #10 clk = ~clk;

  pair_shift_unit u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .instrWord  (instrWord),
    .ready      (ready),
    .rdAddrHi   (rdAddrHi),
    .rdDataHi   (regs[rdAddrHi]),
    .rdAddrLo   (rdAddrLo),
    .rdDataLo   (regs[rdAddrLo]),
    .rdAddrBase (rdAddrBase),
    .rdDataBase (regs[rdAddrBase]),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .done       (done),
    .condCode   (condCode),
    .specErr    (specErr)
  );

  always @(posedge clk) if (wrEn) regs[wrAddr] <= wrData;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(logic [7:0] op, logic [3:0] pr, logic [3:0] pad,
                                     logic [3:0] base, logic [11:0] disp);
    return {op, pr, pad, base, disp};
  endfunction

  // one bit per step, sign kept
  function automatic logic [63:0] refShift(logic [63:0] v, int n);
    logic [63:0] s = v;
    for (int i = 0; i < n; i++) s = {s[63], s[63:1]};
    return s;
  endfunction

  // compare every output one cycle later, sampled at the falling edge
  task automatic tick(logic we, logic [3:0] wa, logic [31:0] wd, logic dn, logic se,
                      logic rdy, string tag);
    logic [40:0] act, exp;
    @(negedge clk);
    startValid = 1'b0;
    act = {wrEn, wrEn ? wrAddr : 4'h0, wrEn ? wrData : 32'h0, done, specErr, condCode, ready};
    exp = {we, wa, wd, dn, se, expCc, rdy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] ins, string tag, bit poke);
    logic [3:0]  pr = ins[23:20];
    logic [3:0]  ev = {pr[3:1], 1'b0};
    logic [3:0]  bs = ins[15:12];
    logic [31:0] bv = (bs == 4'd0) ? 32'd0 : regs[bs];
    int          n  = int'((bv + {20'd0, ins[11:0]}) & 32'h3F);
    logic [63:0] r  = refShift({regs[ev], regs[ev | 4'd1]}, n);
    startValid = 1'b1;
    instrWord  = ins;
    if (pr[0]) begin
      tick(0, 0, 0, 0, 1, 0, {tag, " R8"});
      tick(0, 0, 0, 0, 0, 1, {tag, " R8"});
      return;
    end
    tick(0, 0, 0, 0, 0, 0, {tag, " R9"});
    if (poke) begin startValid = 1'b1; instrWord = mk(8'h00, 4'd3, 0, 0, 1); end
    tick(1, ev, r[63:32], 0, 0, 0, {tag, " R1"});
    if (poke) begin startValid = 1'b1; instrWord = mk(8'h00, 4'd2, 0, 0, 1); end
    tick(1, ev | 4'd1, r[31:0], 0, 0, 0, {tag, " R1"});
    expCc = (r == 64'd0) ? 2'd0 : (r[63] ? 2'd1 : 2'd2);
    tick(0, 0, 0, 1, 0, 0, {tag, " R4"});
    tick(0, 0, 0, 0, 0, 1, {tag, " R9"});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick(0, 0, 0, 0, 0, 1, "reset R10");

    // R3: sign-filled shift by 3, known result FE1E1E1E / 1E1E1E1E
    regs[8] = 32'hF0F0F0F0; regs[9] = 32'hF0F0F0F0;
    run(mk(8'h8E, 4'd8, 0, 0, 12'd3), "R3 shift3", 0);
    if (regs[8] !== 32'hFE1E1E1E || regs[9] !== 32'h1E1E1E1E || condCode !== 2'd1) begin
      errors++;
      $display("FAIL R3: actual %h %h %0d expected fe1e1e1e 1e1e1e1e 1", regs[8], regs[9], condCode);
    end
    checks++;

    // R1: pair 4/5 by one
    regs[4] = 32'hFFFFFFF0; regs[5] = 32'hF0F0F0F0;
    run(mk(8'h8E, 4'd4, 0, 0, 12'd1), "R1 shift1", 0);
    if (regs[4] !== 32'hFFFFFFF8 || regs[5] !== 32'h78787878) begin
      errors++;
      $display("FAIL R1: actual %h %h expected fffffff8 78787878", regs[4], regs[5]);
    end
    checks++;

    // R6: distance 32, positive operand
    regs[6] = 32'h0000000F; regs[7] = 32'h0;
    run(mk(8'h8E, 4'd6, 0, 0, 12'd32), "R6 move32", 0);
    // R6: distance 32, negative operand
    regs[10] = 32'h80000001; regs[11] = 32'h12345678;
    run(mk(8'h8E, 4'd10, 0, 0, 12'd32), "R6 move32neg", 0);

    // R7 and R4: distance 63 on positive (zero result) and negative operands
    regs[12] = 32'h7FFFFFFF; regs[13] = 32'hFFFFFFFF;
    run(mk(8'h8E, 4'd12, 0, 0, 12'd63), "R7 pos63", 0);
    regs[12] = 32'h80000000; regs[13] = 32'h0;
    run(mk(8'h8E, 4'd12, 0, 0, 12'd63), "R7 neg63", 0);

    // R2: distance from a base register, with wrap above bit 5
    regs[3] = 32'd8; regs[8] = 32'h12345678; regs[9] = 32'h9ABCDEF0;
    run(mk(8'h8E, 4'd8, 0, 4'd3, 12'd0), "R2 indirect", 0);
    regs[3] = 32'hFFFF_FF3F;
    run(mk(8'h8E, 4'd8, 0, 4'd3, 12'hFC5), "R2 wrap", 0);
    // R2: base field 0 ignores register 0
    regs[0] = 32'd5;
    run(mk(8'h8E, 4'd8, 0, 4'd0, 12'd2), "R2 base0", 0);

    // R5: opcode and pad bits do not matter
    regs[4] = 32'hC0000000; regs[5] = 32'h00000003;
    run(mk(8'h3C, 4'd4, 4'hF, 0, 12'd4), "R5 padbits", 0);

    // R8: odd pair register, cc must stay as it was
    run(mk(8'h8E, 4'd5, 0, 0, 12'd1), "R8 oddpair", 0);
    if (regs[4] !== 32'hFC000000) begin
      errors++;
      $display("FAIL R8: actual %h expected fc000000", regs[4]);
    end
    checks++;

    // R9: starts while busy are ignored
    regs[14] = 32'h00000000; regs[15] = 32'h00000100;
    run(mk(8'h8E, 4'd14, 0, 0, 12'd8), "R9 busypoke", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule